// File: doc/BRIEF.md
# Dual-Clock FIFO with Last-Operation Flags

This block moves data words from one clock domain to another, unrelated one. A producer on the write clock offers a word with `wr_en`. The word is stored unless the buffer is full. A consumer on the read clock raises `rd_en` to take the oldest word into a registered output. The read is honoured unless the buffer is empty. The storage holds 32 words, addressed by 5-bit pointers. Each pointer crosses to the other domain in Gray code, through a chain of synchronizing flip-flops.

The pointers carry no extra lap bit. Equal pointers can therefore mean either "nothing stored" or "every slot stored". A one-bit mark of the most recent operation tells the two cases apart. The write side sets the mark once it sees the buffer more than half full. The read side clears it once it sees the buffer less than half full. Each domain sees the other's half of the mark through the same synchronizer as the pointer. A flag therefore rises on the edge that causes it and falls a few edges after the other side acts. The scheme relies on the two clock frequencies staying within roughly 3:1 of each other at the default depth.

Top module: `xclk_fifo`

## Requirements
- R1: After reset, with both clocks running, `empty` is 1, `full` is 0 and `rd_data` is 0.
- R2: A write-clock edge with `wr_en`=1 and `full`=0 stores `wr_data` and advances the write location by one, wrapping after the 32nd location. From any starting location, `full` rises only after exactly 32 unread words.
- R3: `rd_data` changes only on a read-clock edge where `rd_en`=1 and `empty`=0, and otherwise holds its value.
- R4: Words leave the buffer in the order they were accepted, including across the wrap of the locations.
- R5: `full` reads 1 right after the write edge that stores the 32nd unread word. Writes offered while `full`=1 are dropped, and none of them ever appears at `rd_data`.
- R6: A read offered while `empty`=1 leaves `rd_data` unchanged and does not move the read location. The next word written is the next word read.
- R7: A pointer sent across domains changes at most one bit per step (Gray code). Every crossing bit passes through two flip-flops in the receiving domain.
- R8: `full` only rises after an accepted write, and `empty` only rises after an accepted read. `empty` reads 1 right after the read edge that takes the last stored word.
- R9: Flags clear late and never early. After a write into an empty buffer, `empty` falls on the 2nd or 3rd read-clock edge. After a read from a full buffer, `full` falls on the 2nd or 3rd write-clock edge.
- R10: With reads and writes running at the same time, at read/write clock ratios within 3:1, every accepted word is delivered exactly once and in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write domain clock |
| rd_clk | input | 1 | Read domain clock |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| wr_en | input | 1 | Offer `wr_data` for storage |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No free location; writes are dropped |
| rd_en | input | 1 | Request the oldest stored word |
| rd_data | output | DATA_W | Registered word from the last accepted read |
| empty | output | 1 | Nothing stored; reads are ignored |

## Verification
Most internal faults reach the ports as data errors. If a pointer steps wrongly, or a stored slot is overwritten, a word appears out of order at `rd_data` on the very next read of that slot. If the last-operation mark is lost or inverted, the buffer reports full when it is empty, or empty when it is full. This shows up at the first equality of the pointers, which is at most 32 accesses away. A synchronizer of the wrong length shows up only as flag timing. The bench therefore counts clock edges between an access and the flag release, and the assertions flag any step of more than one location or any flag that rises without a matching access.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;

    // Pointer geometry: the location count follows from the pointer width.
    localparam int ADDR_W = 5;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int HALF   = DEPTH / 2;

    typedef logic [ADDR_W-1:0] ptr_t;

    // What one domain publishes to the other: its pointer in Gray code
    // plus its half of the last-operation mark.
    typedef struct packed {
        logic mark;
        ptr_t gray;
    } xing_t;

    localparam int XING_W = $bits(xing_t);

    function automatic ptr_t bin2gray(input ptr_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_t gray2bin(input ptr_t g);
        ptr_t b;
        b[ADDR_W-1] = g[ADDR_W-1];
        for (int i = ADDR_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/xclk_fifo_sync.sv
module xclk_fifo_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) begin
                stg[i] <= '0;
            end
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/xclk_fifo_wside.sv
module xclk_fifo_wside
    import xclk_fifo_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  xing_t far,
    output xing_t own,
    output ptr_t  addr,
    output logic  we,
    output logic  full
);

    localparam ptr_t HALF_P = ptr_t'(HALF);
    localparam ptr_t ONE    = ptr_t'(1);

    ptr_t  bin_q;
    xing_t own_q;
    logic  last_wr;
    logic  same;
    ptr_t  gap;
    logic  set_now;

    // Mark halves disagree: the last event seen was a near-full write.
    assign last_wr = own_q.mark ^ far.mark;
    // Bitwise equivalence of the Gray pointers.
    assign same    = &(own_q.gray ~^ far.gray);
    assign full    = last_wr & same;
    assign we      = push & ~full;
    // Occupancy as seen from this side; never less than the true value.
    assign gap     = bin_q - gray2bin(far.gray);
    assign set_now = ~last_wr & (gap > HALF_P);

    always_ff @(posedge clk) begin
        if (rst) begin
            bin_q <= '0;
            own_q <= '0;
        end else begin
            if (we) begin
                bin_q      <= bin_q + ONE;
                own_q.gray <= bin2gray(bin_q + ONE);
            end
            if (set_now) begin
                own_q.mark <= ~own_q.mark;
            end
        end
    end

    assign own  = own_q;
    assign addr = bin_q;

    // R5: a write offered while full leaves the location untouched
    a_r5_hold_full: assert property (@(posedge clk) disable iff (rst)
        (full && push) |=> $stable(bin_q));

    // R2: an accepted write moves exactly one location on
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        we |=> (bin_q == $past(bin_q) + ONE));

    // R7: the published pointer changes in at most one bit per edge
    a_r7_gray_w: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(own_q.gray ^ $past(own_q.gray)) <= 1));

    // R8: full only appears right after an accepted write
    a_r8_full_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(full) |-> $past(we));

endmodule

// File: rtl/xclk_fifo_rside.sv
module xclk_fifo_rside
    import xclk_fifo_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pop,
    input  xing_t far,
    output xing_t own,
    output ptr_t  addr,
    output logic  re,
    output logic  empty
);

    localparam ptr_t HALF_P = ptr_t'(HALF);
    localparam ptr_t ONE    = ptr_t'(1);

    ptr_t  bin_q;
    xing_t own_q;
    logic  last_wr;
    logic  same;
    ptr_t  fill;
    logic  clr_now;

    assign last_wr = far.mark ^ own_q.mark;
    assign same    = &(own_q.gray ~^ far.gray);
    assign empty   = ~last_wr & same;
    assign re      = pop & ~empty;
    // Occupancy as seen from this side; never more than the true value.
    assign fill    = gray2bin(far.gray) - bin_q;
    assign clr_now = last_wr & (fill != '0) & (fill < HALF_P);

    always_ff @(posedge clk) begin
        if (rst) begin
            bin_q <= '0;
            own_q <= '0;
        end else begin
            if (re) begin
                bin_q      <= bin_q + ONE;
                own_q.gray <= bin2gray(bin_q + ONE);
            end
            if (clr_now) begin
                own_q.mark <= ~own_q.mark;
            end
        end
    end

    assign own  = own_q;
    assign addr = bin_q;

    // R6: a read offered while empty leaves the location untouched
    a_r6_hold_empty: assert property (@(posedge clk) disable iff (rst)
        (empty && pop) |=> $stable(bin_q));

    // R7: the published pointer changes in at most one bit per edge
    a_r7_gray_r: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(own_q.gray ^ $past(own_q.gray)) <= 1));

    // R8: empty only appears right after an accepted read
    a_r8_empty_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(empty) |-> $past(re));

endmodule

// File: rtl/xclk_fifo_store.sv
module xclk_fifo_store
    import xclk_fifo_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              wr_clk,
    input  logic              we,
    input  ptr_t              waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_clk,
    input  logic              rst,
    input  logic              re,
    input  ptr_t              raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge wr_clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge rd_clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (re) begin
            rdata_q <= mem[raddr];
        end
    end

    assign rdata = rdata_q;

    // R3: output word holds unless a read is accepted
    a_r3_hold_data: assert property (@(posedge rd_clk) disable iff (rst)
        !re |=> $stable(rdata_q));

endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
    import xclk_fifo_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty
);

    xing_t w_pub;
    xing_t r_pub;
    xing_t w_seen_by_r;
    xing_t r_seen_by_w;
    logic [XING_W-1:0] w2r_q;
    logic [XING_W-1:0] r2w_q;
    ptr_t  waddr;
    ptr_t  raddr;
    logic  we;
    logic  re;

    xclk_fifo_sync #(.W(XING_W), .STAGES(SYNC_STAGES)) u_w2r (
        .clk (rd_clk),
        .rst (rst),
        .d   (w_pub),
        .q   (w2r_q)
    );

    xclk_fifo_sync #(.W(XING_W), .STAGES(SYNC_STAGES)) u_r2w (
        .clk (wr_clk),
        .rst (rst),
        .d   (r_pub),
        .q   (r2w_q)
    );

    assign w_seen_by_r = xing_t'(w2r_q);
    assign r_seen_by_w = xing_t'(r2w_q);

    xclk_fifo_wside u_wside (
        .clk  (wr_clk),
        .rst  (rst),
        .push (wr_en),
        .far  (r_seen_by_w),
        .own  (w_pub),
        .addr (waddr),
        .we   (we),
        .full (full)
    );

    xclk_fifo_rside u_rside (
        .clk   (rd_clk),
        .rst   (rst),
        .pop   (rd_en),
        .far   (w_seen_by_r),
        .own   (r_pub),
        .addr  (raddr),
        .re    (re),
        .empty (empty)
    );

    xclk_fifo_store #(.DATA_W(DATA_W)) u_store (
        .wr_clk (wr_clk),
        .we     (we),
        .waddr  (waddr),
        .wdata  (wr_data),
        .rd_clk (rd_clk),
        .rst    (rst),
        .re     (re),
        .raddr  (raddr),
        .rdata  (rd_data)
    );

endmodule

// File: tb/xclk_fifo_test.sv
module xclk_fifo_test;

    localparam int CLK_PERIOD = 10;
    localparam int NSLOT      = 32;

    logic       wr_clk = 1'b0;
    logic       rd_clk = 1'b0;
    logic       rst    = 1'b1;
    logic       wr_en  = 1'b0;
    logic       rd_en  = 1'b0;
    logic [7:0] wr_data = '0;
    logic       full;
    logic       empty;
    logic [7:0] rd_data;

    int rd_half = 7;
    int checks  = 0;
    int errors  = 0;
    logic [7:0] model [$];

    xclk_fifo uut (
        .wr_clk  (wr_clk),
        .rd_clk  (rd_clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .full    (full),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .empty   (empty)
    );

    initial forever #(CLK_PERIOD / 2) wr_clk = ~wr_clk;
    initial forever #(rd_half) rd_clk = ~rd_clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        wr_en = 1'b0;
        rd_en = 1'b0;
        rst   = 1'b1;
        repeat (4) @(posedge wr_clk);
        repeat (4) @(posedge rd_clk);
        @(negedge wr_clk);
        rst = 1'b0;
        model.delete();
        repeat (3) @(posedge rd_clk);
        repeat (3) @(posedge wr_clk);
    endtask

    task automatic push(input logic [7:0] v, output bit acc);
        @(negedge wr_clk);
        wr_en   = 1'b1;
        wr_data = v;
        acc     = !full;
        @(posedge wr_clk);
        if (acc) model.push_back(v);
        #1 wr_en = 1'b0;
    endtask

    task automatic pop(output bit got, output logic [7:0] v);
        @(negedge rd_clk);
        rd_en = 1'b1;
        got   = !empty;
        @(posedge rd_clk);
        #1 rd_en = 1'b0;
        @(negedge rd_clk);
        v = rd_data;
    endtask

    task automatic pop_check(input string req);
        bit got;
        logic [7:0] v;
        logic [7:0] exp;
        pop(got, v);
        check(got, req, int'(got), 1);
        if (got) begin
            exp = (model.size() > 0) ? model.pop_front() : 8'h00;
            check(v == exp, req, int'(v), int'(exp));
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge rd_clk);
        check(empty == 1'b1, "R1", int'(empty), 1);
        check(full == 1'b0, "R1", int'(full), 0);
        check(rd_data == 8'h00, "R1", int'(rd_data), 0);
    endtask

    task automatic t_fill_drain();
        bit acc;
        bit got;
        logic [7:0] v;
        logic [7:0] keep;
        int taken = 0;
        for (int i = 0; i < NSLOT; i++) begin
            if (i == NSLOT - 1) begin
                @(negedge wr_clk);
                check(full == 1'b0, "R8 before last slot", int'(full), 0);
            end
            push(8'(i * 7 + 3), acc);
            if (acc) taken++;
        end
        check(taken == NSLOT, "R2 accepted count", taken, NSLOT);
        @(negedge wr_clk);
        check(full == 1'b1, "R5 full after 32", int'(full), 1);
        for (int i = 0; i < 3; i++) begin
            push(8'hEE, acc);
            check(!acc, "R5 write while full", int'(acc), 0);
        end
        @(negedge wr_clk);
        check(full == 1'b1, "R5 still full", int'(full), 1);
        repeat (4) @(posedge rd_clk);
        for (int i = 0; i < NSLOT; i++) begin
            pop_check("R4 order");
        end
        check(empty == 1'b1, "R8 empty after last read", int'(empty), 1);
        keep = rd_data;
        pop(got, v);
        check(!got, "R6 read while empty", int'(got), 0);
        check(v == keep, "R6 data unchanged", int'(v), int'(keep));
        repeat (3) @(posedge rd_clk);
        @(negedge rd_clk);
        check(rd_data == keep, "R3 hold without read", int'(rd_data), int'(keep));
        push(8'h77, acc);
        repeat (5) @(posedge rd_clk);
        pop_check("R6 next word after empty read");
    endtask

    task automatic t_wrap();
        bit acc;
        for (int i = 0; i < 20; i++) push(8'(100 + i), acc);
        repeat (4) @(posedge rd_clk);
        for (int i = 0; i < 20; i++) pop_check("R4 partial");
        repeat (4) @(posedge wr_clk);
        for (int i = 0; i < NSLOT; i++) begin
            if (i == NSLOT - 1) begin
                @(negedge wr_clk);
                check(full == 1'b0, "R2 not full at 31", int'(full), 0);
            end
            push(8'(200 + i), acc);
            check(acc, "R2 write across wrap", int'(acc), 1);
        end
        @(negedge wr_clk);
        check(full == 1'b1, "R2 full at 32 after wrap", int'(full), 1);
        repeat (4) @(posedge rd_clk);
        for (int i = 0; i < NSLOT; i++) pop_check("R4 across wrap");
        check(empty == 1'b1, "R8 empty after wrap drain", int'(empty), 1);
    endtask

    task automatic t_latency();
        bit acc;
        int n;
        @(negedge wr_clk);
        wr_en   = 1'b1;
        wr_data = 8'h5A;
        @(posedge wr_clk);
        model.push_back(8'h5A);
        #1 wr_en = 1'b0;
        n = 0;
        do begin
            @(posedge rd_clk);
            n++;
            @(negedge rd_clk);
        end while (empty && n < 8);
        check(!empty && n >= 2 && n <= 3, "R9 empty release edges", n, 2);
        pop_check("R9 word after release");
        for (int i = 0; i < NSLOT; i++) push(8'(40 + i), acc);
        repeat (4) @(posedge rd_clk);
        @(negedge rd_clk);
        rd_en = 1'b1;
        @(posedge rd_clk);
        #1 rd_en = 1'b0;
        void'(model.pop_front());
        n = 0;
        do begin
            @(posedge wr_clk);
            n++;
            @(negedge wr_clk);
        end while (full && n < 8);
        check(!full && n >= 2 && n <= 3, "R9 full release edges", n, 2);
        @(negedge rd_clk);
        check(rd_data == 8'd40, "R3 read from full", int'(rd_data), 40);
        for (int i = 1; i < NSLOT; i++) pop_check("R4 drain after release");
    endtask

    task automatic t_stream(input int half, input int count);
        rd_half = half;
        do_reset();
        fork
            begin
                bit acc;
                for (int i = 0; i < count; i++) begin
                    acc = 1'b0;
                    while (!acc) push(8'(i * 13 + half), acc);
                end
            end
            begin
                bit got;
                logic [7:0] v;
                logic [7:0] exp;
                int seen = 0;
                while (seen < count) begin
                    pop(got, v);
                    if (got) begin
                        seen++;
                        if (model.size() == 0) begin
                            check(1'b0, "R10 word with no write", int'(v), -1);
                        end else begin
                            exp = model.pop_front();
                            check(v == exp, "R10 stream order", int'(v), int'(exp));
                        end
                    end
                end
            end
        join
        repeat (4) @(posedge rd_clk);
        @(negedge rd_clk);
        check(empty == 1'b1, "R10 empty at end", int'(empty), 1);
        check(model.size() == 0, "R10 nothing lost", model.size(), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_fill_drain();
        t_wrap();
        t_latency();
        t_stream(3, 150);
        t_stream(5, 150);
        t_stream(13, 150);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule